// File: doc/BRIEF.md
# Serial Audio Frame-Sync Generator

This block makes the timing for a serial audio port that carries two words per frame. When the port is the timing master, it divides a source clock down to a bit clock. It counts bit clocks into frames and drives a frame-sync strobe. There is one strobe for the transmit side and one for the receive side, and each has its own polarity. A one-cycle frame-start indication tells the shifters when a new frame begins.

Software brings the block up in two stages. First the sample generator is enabled, which starts the bit clock. Later the frame-sync generator is enabled, which starts the frame counter. A single stop drops both enables together.

A clock-mode input picks one of three setups:
- The bit clock and the frame sync are both made inside the block.
- The bit clock comes from a pin outside the block, and the frame sync is still made inside.
- Both come from outside. In this setup the block drives nothing and passes the outside frame sync through.

Frames either run continuously or start one at a time on a write request.

There is no data stream through this block, so it has no handshake. Every pin is a plain control or status level.

Top module: `afs_fsync_gen`

## Requirements
- R1: A frame lasts `period_m1`+1 bit clocks. Consecutive `frame_start` strobes are that many bit clocks apart.
- R2: The frame-sync strobe is active for `width_m1`+1 bit clocks at the start of each frame, when `width_m1` ≤ `period_m1`.
- R3: With `free_run`=1, frames repeat without pause. With `free_run`=0, one frame is sent for each `wr_strobe` pulse, and the block then idles with the strobe inactive.
- R4: While `gen_en`=1 and `fs_en`=0, the bit clock runs but no frame-sync strobe and no `frame_start` are produced.
- R5: When `fs_en` rises with `gen_en` high, the frame counter starts again from zero. The first strobe and `frame_start` appear on the first bit-clock rising edge after the release, within 2·DIV+1 source cycles.
- R6: Dropping `gen_en` and `fs_en` together stops the bit clock at low. Both strobes return to their inactive level by the next source clock.
- R7: `fsx_low`=1 makes the transmit strobe active-low, and `fsr_low` does the same for the receive strobe. When a strobe is idle or held in reset, it sits at its inactive level, which is the value of its polarity bit.
- R8: With `clk_mode`=2'b00, `bclk_out` is the source clock divided by 2·DIV. Both `bclk_oe` and `fs_oe` are 1.
- R9: With `clk_mode`=2'b01, frames are timed by rising edges of `ext_bclk` after synchronisation. `bclk_oe`=0 and `fs_oe`=1.
- R10: With `clk_mode[1]`=1, both output enables are 0 and `fsx_out`/`fsr_out` equal `ext_fs`. `frame_start` pulses once for each edge of `ext_fs` into its active level, as set by `fsr_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Sample generator enable (bit clock) |
| fs_en | input | 1 | Frame-sync generator enable |
| free_run | input | 1 | 1: continuous frames, 0: frame per write request |
| wr_strobe | input | 1 | Write request; starts one frame when free_run=0 |
| clk_mode | input | 2 | 00 internal, 01 external bit clock, 1x slave |
| period_m1 | input | PW | Frame length in bit clocks, minus one |
| width_m1 | input | PW | Strobe length in bit clocks, minus one |
| fsx_low | input | 1 | Transmit strobe active-low when 1 |
| fsr_low | input | 1 | Receive strobe active-low when 1 |
| ext_bclk | input | 1 | Bit clock from outside |
| ext_fs | input | 1 | Frame sync from outside |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| fsx_out | output | 1 | Transmit frame-sync strobe |
| fsr_out | output | 1 | Receive frame-sync strobe |
| fs_oe | output | 1 | Drive enable for the frame-sync pins |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a frame |

## Verification
The hardest case to reach from the ports is a one-shot frame ending at its last bit clock with no further write pending. The frame counter must drop to idle there instead of wrapping. The stimulus reaches it by clearing `free_run`, enabling both stages, and leaving the block idle to show that nothing starts. It then gives one `wr_strobe` pulse and counts frame starts over three frame lengths. The external bit-clock case is reached with a bench-driven square wave whose period is not a multiple of the internal divider. Correct spacing there shows that timing follows the outside edges.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic [1:0] {
    CM_MASTER   = 2'b00,
    CM_EXT_BCLK = 2'b01,
    CM_SLAVE    = 2'b10,
    CM_SLAVE_B  = 2'b11
  } clk_mode_e;

  function automatic logic mode_is_slave(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_ext_bclk(input logic [1:0] m);
    return (m == CM_EXT_BCLK);
  endfunction

endpackage

// File: rtl/afs_bclk_div.sv
module afs_bclk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic bclk_q;

  generate
    if (DIV == 1) begin : g_nodiv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bclk_q <= 1'b0;
        else if (!en) bclk_q <= 1'b0;
        else          bclk_q <= ~bclk_q;
      end
      assign tick = en && !bclk_q;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          bclk_q <= 1'b0;
        end else if (!en) begin
          cnt_q  <= '0;
          bclk_q <= 1'b0;
        end else if (wrap) begin
          cnt_q  <= '0;
          bclk_q <= ~bclk_q;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
      assign tick = en && wrap && !bclk_q;
    end
  endgenerate

  assign bclk = bclk_q;

  // R6: once the generator is held off the clock parks low and stops ticking
  p_park_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !tick));

  // R8: a rising bit-clock edge never happens on two cycles in a row
  p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/afs_edge_sync.sv
module afs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/afs_frame_ctr.sv
module afs_frame_ctr #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          free_run,
  input  logic          wr_strobe,
  input  logic [PW-1:0] period_m1,
  input  logic [PW-1:0] width_m1,
  output logic          active,
  output logic          running,
  output logic          start_q
);
  logic [PW-1:0] pos_q;
  logic          run_q;
  logic          pend_q;
  logic          at_end;
  logic          want;
  logic          begin_frame;

  assign at_end      = !run_q || (pos_q == period_m1);
  assign want        = free_run || pend_q || wr_strobe;
  assign begin_frame = enable && tick && at_end && want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (!enable) begin
      pos_q   <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= begin_frame;
      if (wr_strobe) pend_q <= 1'b1;
      if (tick) begin
        if (!at_end) begin
          pos_q <= pos_q + 1'b1;
        end else if (want) begin
          run_q  <= 1'b1;
          pos_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          run_q  <= 1'b0;
          pos_q  <= '0;
        end
      end
    end
  end

  assign active  = run_q && (pos_q <= width_m1);
  assign running = run_q;

  // R5: a frame start always lands on position zero of a running frame
  p_start_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (run_q && pos_q == '0));

  // R4: with the frame-sync stage held off, nothing runs on the next cycle
  p_held_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!run_q && !start_q));

  // R1: the position only moves on a bit-clock edge
  p_pos_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(pos_q));

  // R3: a one-shot frame with nothing pending ends at its last bit clock
  p_oneshot_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && run_q && pos_q == period_m1 && !free_run && !pend_q && !wr_strobe)
      |=> !run_q);

endmodule

// File: rtl/afs_fsync_gen.sv
module afs_fsync_gen
  import afs_pkg::*;
#(
  parameter int PW     = 8,
  parameter int DIV    = 2,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          fs_en,
  input  logic          free_run,
  input  logic          wr_strobe,
  input  logic [1:0]    clk_mode,
  input  logic [PW-1:0] period_m1,
  input  logic [PW-1:0] width_m1,
  input  logic          fsx_low,
  input  logic          fsr_low,
  input  logic          ext_bclk,
  input  logic          ext_fs,
  output logic          bclk_out,
  output logic          bclk_oe,
  output logic          fsx_out,
  output logic          fsr_out,
  output logic          fs_oe,
  output logic          frame_start
);
  logic is_slave, is_ext;
  logic int_bclk, int_tick;
  logic ext_rise, fs_act_rise;
  logic bit_tick;
  logic fr_enable, fr_active, fr_running, fr_start;

  assign is_slave = mode_is_slave(clk_mode);
  assign is_ext   = mode_is_ext_bclk(clk_mode);

  afs_bclk_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (gen_en && (clk_mode == CM_MASTER)),
    .bclk  (int_bclk),
    .tick  (int_tick)
  );

  afs_edge_sync #(.STAGES(SYNC_N)) u_bclk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_bclk),
    .rise  (ext_rise)
  );

  afs_edge_sync #(.STAGES(SYNC_N)) u_fs_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_fs ^ fsr_low),
    .rise  (fs_act_rise)
  );

  assign bit_tick  = is_ext ? (gen_en && ext_rise) : int_tick;
  assign fr_enable = gen_en && fs_en && !is_slave;

  afs_frame_ctr #(.PW(PW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (fr_enable),
    .tick      (bit_tick),
    .free_run  (free_run),
    .wr_strobe (wr_strobe),
    .period_m1 (period_m1),
    .width_m1  (width_m1),
    .active    (fr_active),
    .running   (fr_running),
    .start_q   (fr_start)
  );

  assign bclk_out    = int_bclk;
  assign bclk_oe     = (clk_mode == CM_MASTER);
  assign fs_oe       = !is_slave;
  assign fsx_out     = is_slave ? ext_fs : (fr_active ^ fsx_low);
  assign fsr_out     = is_slave ? ext_fs : (fr_active ^ fsr_low);
  assign frame_start = is_slave ? fs_act_rise : fr_start;

  // R7: an idle generator holds each strobe at its own inactive level
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_slave && !fr_running) |-> (fsx_out == fsx_low && fsr_out == fsr_low));

  // R10: in slave mode the pins are never driven
  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (!bclk_oe && !fs_oe && !int_bclk));

endmodule

// File: tb/afs_fsync_gen_bench.sv
module afs_fsync_gen_bench;
  localparam int PW  = 8;
  localparam int DIV = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gen_en = 0, fs_en = 0, free_run = 1, wr_strobe = 0;
  logic [1:0]    clk_mode = 2'b00;
  logic [PW-1:0] period_m1 = 8'd31, width_m1 = 8'd15;
  logic          fsx_low = 1, fsr_low = 0, ext_bclk = 0, ext_fs = 0;
  logic          bclk_out, bclk_oe, fsx_out, fsr_out, fs_oe, frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  logic ext_run = 0;
  int   ext_cnt = 0;

  always #10 clk = ~clk;

  afs_fsync_gen #(.PW(PW), .DIV(DIV), .SYNC_N(2)) u_afs_fsync_gen (
    .clk, .rst_n, .gen_en, .fs_en, .free_run, .wr_strobe, .clk_mode,
    .period_m1, .width_m1, .fsx_low, .fsr_low, .ext_bclk, .ext_fs,
    .bclk_out, .bclk_oe, .fsx_out, .fsr_out, .fs_oe, .frame_start
  );

  // outside bit clock: period 6 source cycles
  always @(posedge clk) begin
    if (ext_run) begin
      if (ext_cnt == 2) begin ext_cnt <= 0; ext_bclk <= ~ext_bclk; end
      else ext_cnt <= ext_cnt + 1;
    end else begin
      ext_cnt <= 0; ext_bclk <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_all();
    @(posedge clk); #2; gen_en = 0; fs_en = 0;
    cyc(3);
  endtask

  // wait for a frame start, then time one whole frame
  task automatic measure(output int per, output int wid, output int polbad);
    int guard = 0;
    per = 0; wid = 0; polbad = 0;
    while (!frame_start && guard < 2000) begin @(negedge clk); guard++; end
    do begin
      per++;
      if (fsx_out != fsx_low) wid++;
      if ((fsx_out ^ fsx_low) != (fsr_out ^ fsr_low)) polbad++;
      @(negedge clk);
    end while (!frame_start && per < 4000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bclk_out == 0, "R6 reset bclk", bclk_out, 0);
    check(fsx_out == 1, "R7 reset fsx inactive", fsx_out, 1);
    check(fsr_out == 0, "R7 reset fsr inactive", fsr_out, 0);
    check(frame_start == 0, "R4 reset no start", frame_start, 0);
  endtask

  task automatic t_two_stage();
    int rises = 0, starts = 0, act = 0;
    logic prev;
    @(posedge clk); #2; clk_mode = 2'b00; free_run = 1; gen_en = 1;
    cyc(4);
    prev = bclk_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_out && !prev) rises++;
      prev = bclk_out;
      if (frame_start) starts++;
      if (fsx_out != fsx_low || fsr_out != fsr_low) act++;
    end
    check(rises == 40 / (2 * DIV), "R8 bclk rate", rises, 40 / (2 * DIV));
    check(bclk_oe == 1 && fs_oe == 1, "R8 oe master", {bclk_oe, fs_oe}, 3);
    check(starts == 0, "R4 no start before fs_en", starts, 0);
    check(act == 0, "R4 no strobe before fs_en", act, 0);
  endtask

  task automatic t_first_pulse();
    int wait_c = 0;
    @(posedge clk); #2; fs_en = 1;
    @(negedge clk); wait_c = 1;
    while (!frame_start && wait_c < 50) begin @(negedge clk); wait_c++; end
    check(wait_c <= 2 * DIV + 1, "R5 first pulse delay", wait_c, 2 * DIV + 1);
    check(fsx_out == 0 && fsr_out == 1, "R7 active levels", {fsx_out, fsr_out}, 1);
  endtask

  task automatic t_free_run(input int p, input int w);
    int per, wid, pb;
    stop_all();
    @(posedge clk); #2; period_m1 = PW'(p); width_m1 = PW'(w); gen_en = 1;
    cyc(3);
    @(posedge clk); #2; fs_en = 1;
    measure(per, wid, pb);
    measure(per, wid, pb);
    check(per == (p + 1) * 2 * DIV, "R1 frame period", per, (p + 1) * 2 * DIV);
    check(wid == (w + 1) * 2 * DIV, "R2 strobe width", wid, (w + 1) * 2 * DIV);
    check(pb == 0, "R7 per-strobe polarity", pb, 0);
  endtask

  task automatic t_stop();
    int starts = 0;
    @(posedge clk); #2; gen_en = 0; fs_en = 0;
    cyc(2);
    check(bclk_out == 0, "R6 bclk parked", bclk_out, 0);
    check(fsx_out == fsx_low && fsr_out == fsr_low, "R6 strobes inactive",
          {fsx_out, fsr_out}, {fsx_low, fsr_low});
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (frame_start) starts++; end
    check(starts == 0, "R6 no frames after stop", starts, 0);
  endtask

  task automatic t_trigger();
    int starts = 0;
    @(posedge clk); #2; period_m1 = 8'd7; width_m1 = 8'd3; free_run = 0;
    gen_en = 1; fs_en = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (frame_start) starts++; end
    check(starts == 0, "R3 idle without write", starts, 0);
    @(posedge clk); #2; wr_strobe = 1;
    @(posedge clk); #2; wr_strobe = 0;
    for (int i = 0; i < 8 * 2 * DIV * 3; i++) begin @(negedge clk); if (frame_start) starts++; end
    check(starts == 1, "R3 one frame per write", starts, 1);
    check(fsx_out == fsx_low, "R3 idle after one-shot", fsx_out, fsx_low);
    stop_all();
    @(posedge clk); #2; free_run = 1;
  endtask

  task automatic t_ext();
    int per, wid, pb;
    @(posedge clk); #2; clk_mode = 2'b01; period_m1 = 8'd7; width_m1 = 8'd3;
    ext_run = 1; gen_en = 1; fs_en = 1;
    measure(per, wid, pb);
    measure(per, wid, pb);
    check(per == 8 * 6, "R9 ext frame period", per, 48);
    check(wid == 4 * 6, "R9 ext strobe width", wid, 24);
    check(bclk_oe == 0 && fs_oe == 1, "R9 oe ext bclk", {bclk_oe, fs_oe}, 1);
    stop_all();
    @(posedge clk); #2; ext_run = 0;
  endtask

  task automatic t_slave();
    int starts = 0, follow_bad = 0;
    @(posedge clk); #2; clk_mode = 2'b10; gen_en = 1; fs_en = 1; fsr_low = 0;
    cyc(4);
    check(bclk_oe == 0 && fs_oe == 0, "R10 oe slave", {bclk_oe, fs_oe}, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2; ext_fs = 1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (frame_start) starts++;
        if (fsx_out != 1 || fsr_out != 1) follow_bad++;
      end
      @(posedge clk); #2; ext_fs = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (frame_start) starts++;
        if (fsx_out != 0 || fsr_out != 0) follow_bad++;
      end
    end
    check(starts == 3, "R10 start per ext edge", starts, 3);
    check(follow_bad == 0, "R10 pass-through", follow_bad, 0);
    stop_all();
  endtask

  initial begin
    cyc(3);
    @(posedge clk); #2; rst_n = 1;
    t_reset();
    t_two_stage();
    t_first_pulse();
    t_free_run(31, 15);
    t_free_run(9, 0);
    t_stop();
    t_trigger();
    t_ext();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule